// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven master for the two-wire PHY management bus. Software writes four 32-bit registers (configuration, control, address and data), and some of those writes launch a serial management frame toward the PHYs. The block derives the MDC clock from the system clock through a programmable divider. It drives MDIO through a separate output and output enable, and samples the returned MDIO level on the rising MDC edge. A programmable hold count delays each MDIO change after the MDC falling edge, so that slow PHYs see clean data.

Two frame encodings are supported. In the legacy encoding, a data-register write performs a register write, and a control write with the read bit set performs a register read. In the extended encoding, an address frame is sent first when the address register is written. The data write and the read then follow as separate frames. Busy status is split between the configuration register (address frames) and the data register (write and read frames). A missing turnaround response during a read is latched as an error.

Top module: `mdio_master`

## Requirements
- R1: After reset every register field and flag reads as zero, MDC is low and MDIO is released (output enable low).
- R2: While a frame is in progress MDC has a period of 2×(div+1) system clocks, where div is configuration bits [7:0]. Between frames MDC stays low.
- R3: MDIO output changes exactly `hold` system clocks after an MDC falling edge, where hold is configuration bits [10:8] and hold < div+1. It never changes while MDC is high.
- R4: Every frame is 64 bits, sent MSB first: 32 ones, start(2), opcode(2), port/PHY address(5), register/device number(5), turnaround(2), data(16). Legacy frames use start 01 with opcode 01 for write and 10 for read. Extended frames (configuration bit 12 set) use start 00 with opcode 00 for address, 01 for write and 11 for read. Turnaround is 10 on driven frames.
- R5: The control register holds the read bit at [15], the port/PHY address at [9:5] and the register/device number at [4:0]. In legacy mode a data-register write sends a write frame carrying data[15:0], and an address-register write sends nothing.
- R6: In extended mode an address-register write sends an address frame carrying address[15:0]. Configuration bit 31 reads 1 from the cycle after the write until the frame ends, and data-register bit 31 stays 0.
- R7: For write and read frames, data-register bit 31 reads 1 until the frame ends. After a read, data[15:0] holds the 16 bits sampled from the PHY.
- R8: During a read the master releases MDIO for both turnaround bits and all 16 data bits. If the second turnaround bit is sampled high, configuration bit 30 (read error) is set.
- R9: The read-error flag clears when the next read frame starts.
- R10: A write that would launch a frame while a frame is in progress is ignored: no register changes and no additional frame is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 config, 1 control, 2 address, 3 data |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock to PHYs |
| mdio_i | input | 1 | Sampled MDIO line level |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
Frames are captured bit by bit on each MDC rise and compared whole against an expected 64-bit vector. This is done for legacy write and read, and for extended address, write and read, so that start, opcode and field placement are distinguished between the modes. A PHY model that answers reads is contrasted with a silent line, which separates a correct capture from the error flag; a following read shows that the flag clears. Two divider/hold settings measure the MDC period and the delay from the falling edge to the first data change. Writes that arrive during an active frame check that neither register contents nor line activity change.

// File: rtl/mdio_pkg.sv
// Shared constants, register layout and frame composition for the MDIO master.
// Assumes the fixed 64-bit frame with a full 32-bit preamble.
package mdio_pkg;
    localparam int FRAME_BITS   = 64;
    localparam int REL_IDX      = 46;  // first turnaround bit (released on reads)
    localparam int TA_CHK_IDX   = 47;  // second turnaround bit, sampled for error
    localparam int DATA_IDX     = 48;  // first data bit
    localparam int CFG_HOLD_LSB = 8;
    localparam int CFG_EXT_BIT  = 12;
    localparam int CFG_ERR_BIT  = 30;
    localparam int BUSY_BIT     = 31;
    localparam int CTL_RD_BIT   = 15;

    typedef enum logic [1:0] {SEL_CFG = 2'd0, SEL_CTRL = 2'd1, SEL_ADDR = 2'd2, SEL_DATA = 2'd3} reg_sel_e;
    typedef enum logic [1:0] {K_ADDR = 2'd0, K_WRITE = 2'd1, K_READ = 2'd2} kind_e;

    // Build the full 64-bit frame, MSB sent first.
    function automatic logic [FRAME_BITS-1:0] build_frame(input logic ext, input kind_e kind,
                                                          input logic [4:0] pa, input logic [4:0] ra,
                                                          input logic [15:0] payload);
        logic [1:0] st, op, ta;
        logic [15:0] pl;
        st = ext ? 2'b00 : 2'b01;
        ta = 2'b10;
        pl = payload;
        case (kind)
            K_ADDR:  op = 2'b00;
            K_WRITE: op = 2'b01;
            default: begin
                op = ext ? 2'b11 : 2'b10;
                ta = 2'b11;
                pl = 16'hFFFF;
            end
        endcase
        return {32'hFFFF_FFFF, st, op, pa, ra, ta, pl};
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
// MDC generator and hold timer. Runs only while en is high; MDC idles low.
// Emits a rise pulse on the cycle MDC goes high and an update pulse `hold`
// clocks after MDC falls. Assumes hold < div+1.
module mdio_clkgen #(
    parameter int DIV_W  = 8,
    parameter int HOLD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DIV_W-1:0]  div,
    input  logic [HOLD_W-1:0] hold,
    output logic              mdc,
    output logic              rise,
    output logic              upd
);
    logic [DIV_W-1:0]  cnt;
    logic [HOLD_W-1:0] hcnt;
    logic              half_done;
    logic              fall;

    assign half_done = en && (cnt == div);
    assign rise      = half_done && !mdc;
    assign fall      = half_done && mdc;
    assign upd       = (fall && (hold == '0)) || (hcnt == HOLD_W'(1));

    // Half-period counter and MDC toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (half_done) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Hold countdown started on each MDC falling edge
    always_ff @(posedge clk) begin
        if (!rst_n || !en)
            hcnt <= '0;
        else if (fall && (hold != '0))
            hcnt <= hold;
        else if (hcnt != '0)
            hcnt <= hcnt - 1'b1;
    end

    assert_mdc_idle_R2: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !mdc);
endmodule

// File: rtl/mdio_engine.sv
// Frame shifter: shifts out a 64-bit frame MSB first on update pulses,
// releases the line for turnaround and data of reads, captures read bits
// on MDC rise and flags the turnaround sample cycle. Assumes start only when idle.
module mdio_engine
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  is_read,
    input  logic                  rise,
    input  logic                  upd,
    input  logic                  mdio_i,
    output logic                  active,
    output logic                  done,
    output logic                  ta_chk,
    output logic [15:0]           rd_bits,
    output logic                  mdio_o,
    output logic                  mdio_oe
);
    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BITS - 1);

    logic [IDX_W-1:0]      idx;
    logic [FRAME_BITS-1:0] sr;
    logic                  rd_mode;

    assign done    = active && upd && (idx == LAST);
    assign ta_chk  = active && rise && rd_mode && (idx == IDX_W'(TA_CHK_IDX));
    assign mdio_o  = active && sr[FRAME_BITS-1];
    assign mdio_oe = active && !(rd_mode && (idx >= IDX_W'(REL_IDX)));

    // Frame sequencing: load, shift on update, stop after the last bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            idx     <= '0;
            sr      <= '0;
            rd_mode <= 1'b0;
        end else if (start && !active) begin
            active  <= 1'b1;
            idx     <= '0;
            sr      <= frame;
            rd_mode <= is_read;
        end else if (active && upd) begin
            if (idx == LAST) begin
                active <= 1'b0;
            end else begin
                idx <= idx + 1'b1;
                sr  <= {sr[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    // Read capture of the 16 data bits on MDC rise
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_bits <= '0;
        else if (active && rise && rd_mode && (idx >= IDX_W'(DATA_IDX)))
            rd_bits <= {rd_bits[14:0], mdio_i};
    end

    assert_idle_released_R8: assert property (@(posedge clk) disable iff (!rst_n) !active |-> !mdio_oe);
endmodule

// File: rtl/mdio_master.sv
// Register-mapped MDIO master top. Decodes register writes, decides which
// writes launch frames, tracks split busy flags and the latched read error.
// Assumes software keeps hold < div+1 and does not change config mid-frame.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int HOLD_W = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  reg_sel,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);
    logic [DIV_W-1:0]  div_q;
    logic [HOLD_W-1:0] hold_q;
    logic              ext_q, cfg_busy, data_busy, rd_err;
    logic [4:0]        pa_q, ra_q;
    logic [15:0]       addr_q, data_q;

    logic wr_cfg, wr_ctrl, wr_addr, wr_data;
    logic go_addr, go_write, go_read, go_any, blocked, launch;
    logic eng_active, eng_done, ta_chk, rise, upd;
    logic [15:0] rd_bits;
    logic [4:0]  pa_n, ra_n;
    kind_e       kind;
    logic [FRAME_BITS-1:0] frame;

    assign wr_cfg  = reg_wr && (reg_sel == SEL_CFG);
    assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
    assign wr_addr = reg_wr && (reg_sel == SEL_ADDR);
    assign wr_data = reg_wr && (reg_sel == SEL_DATA);

    assign go_addr  = wr_addr && ext_q;
    assign go_write = wr_data;
    assign go_read  = wr_ctrl && reg_wdata[CTL_RD_BIT];
    assign go_any   = go_addr || go_write || go_read;
    assign blocked  = go_any && eng_active;
    assign launch   = go_any && !eng_active;

    // Frame field selection from the values being written this cycle
    always_comb begin
        pa_n  = go_read ? reg_wdata[9:5] : pa_q;
        ra_n  = go_read ? reg_wdata[4:0] : ra_q;
        kind  = go_addr ? K_ADDR : (go_read ? K_READ : K_WRITE);
        frame = build_frame(ext_q, kind, pa_n, ra_n, go_addr ? reg_wdata[15:0] : reg_wdata[15:0]);
    end

    // Configuration and address/control storage; launch writes dropped while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            hold_q <= '0;
            ext_q  <= 1'b0;
            pa_q   <= '0;
            ra_q   <= '0;
            addr_q <= '0;
        end else if (!blocked) begin
            if (wr_cfg) begin
                div_q  <= reg_wdata[DIV_W-1:0];
                hold_q <= reg_wdata[CFG_HOLD_LSB +: HOLD_W];
                ext_q  <= reg_wdata[CFG_EXT_BIT];
            end
            if (wr_ctrl) begin
                pa_q <= reg_wdata[9:5];
                ra_q <= reg_wdata[4:0];
            end
            if (wr_addr)
                addr_q <= reg_wdata[15:0];
        end
    end

    // Data register: software write or read result at frame end
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (eng_done && data_busy && (kind_q == K_READ))
            data_q <= rd_bits;
        else if (wr_data && !blocked)
            data_q <= reg_wdata[15:0];
    end

    kind_e kind_q;
    // Busy flags, frame kind and latched read error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_busy  <= 1'b0;
            data_busy <= 1'b0;
            rd_err    <= 1'b0;
            kind_q    <= K_ADDR;
        end else begin
            if (launch) begin
                cfg_busy  <= go_addr;
                data_busy <= !go_addr;
                kind_q    <= kind;
            end else if (eng_done) begin
                cfg_busy  <= 1'b0;
                data_busy <= 1'b0;
            end
            if (launch && go_read)
                rd_err <= 1'b0;
            else if (ta_chk && mdio_i)
                rd_err <= 1'b1;
        end
    end

    // Register read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_CFG: begin
                reg_rdata[DIV_W-1:0]                = div_q;
                reg_rdata[CFG_HOLD_LSB +: HOLD_W]   = hold_q;
                reg_rdata[CFG_EXT_BIT]              = ext_q;
                reg_rdata[CFG_ERR_BIT]              = rd_err;
                reg_rdata[BUSY_BIT]                 = cfg_busy;
            end
            SEL_CTRL: reg_rdata[9:0] = {pa_q, ra_q};
            SEL_ADDR: reg_rdata[15:0] = addr_q;
            default: begin
                reg_rdata[15:0]     = data_q;
                reg_rdata[BUSY_BIT] = data_busy;
            end
        endcase
    end

    mdio_clkgen #(.DIV_W(DIV_W), .HOLD_W(HOLD_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .en(eng_active), .div(div_q), .hold(hold_q),
        .mdc(mdc), .rise(rise), .upd(upd)
    );

    mdio_engine u_eng (
        .clk(clk), .rst_n(rst_n), .start(launch), .frame(frame), .is_read(go_read),
        .rise(rise), .upd(upd), .mdio_i(mdio_i), .active(eng_active), .done(eng_done),
        .ta_chk(ta_chk), .rd_bits(rd_bits), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    assert_busy_split_R6: assert property (@(posedge clk) disable iff (!rst_n) !(cfg_busy && data_busy));
    assert_busy_tracks_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_busy || data_busy) |-> eng_active);
    assert_stable_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_active && mdc && $past(mdc)) |-> $stable(mdio_o));
    assert_ignore_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && !eng_done) |=> ($stable(data_q) && $stable(pa_q) && $stable(addr_q)));
endmodule

// File: tb/tb_mdio_master.sv
// Directed bench: one task per scenario, with a PHY model and a line monitor.
module tb_mdio_master;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic mdc, mdio_i, mdio_o, mdio_oe;
    int n_checks = 0, n_fail = 0;

    // PHY model controls (written by tasks only)
    logic phy_en = 1'b0, phy_read = 1'b0;
    logic [15:0] phy_val = '0;
    // Monitor state (written by the monitor only)
    logic phy_drv = 1'b0, phy_bit = 1'b0, mdc_q = 1'b0, oe_q = 1'b0;
    logic [63:0] mon_bits = '0, mon_oe = '0;
    int mon_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign mdio_i = phy_drv ? phy_bit : 1'b1;

    mdio_master dut (.clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_i(mdio_i),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe));

    // Line monitor and PHY responder
    always @(negedge clk) begin
        if (mdio_oe && !oe_q) mon_cnt = 0;
        if (mdc && !mdc_q) begin
            mon_bits = {mon_bits[62:0], (mdio_oe ? mdio_o : mdio_i)};
            mon_oe   = {mon_oe[62:0], mdio_oe};
            mon_cnt  = mon_cnt + 1;
            if (phy_en && phy_read && mon_cnt >= 47 && mon_cnt <= 63) begin
                phy_drv = 1'b1;
                phy_bit = (mon_cnt == 47) ? 1'b0 : phy_val[63 - mon_cnt];
            end else begin
                phy_drv = 1'b0;
            end
        end
        mdc_q = mdc;
        oe_q  = mdio_oe;
    end

    function automatic logic [63:0] exp_frame(input logic ext, input logic [1:0] op,
                                              input logic [9:0] addrs, input logic [15:0] d);
        logic [1:0] ta;
        ta = ((op == 2'b10 && !ext) || (op == 2'b11 && ext)) ? 2'b11 : 2'b10;
        return {32'hFFFF_FFFF, (ext ? 2'b00 : 2'b01), op, addrs, ta, d};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] d);
        @(negedge clk); reg_sel = s; #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] c, dd;
        for (int i = 0; i < 4000; i++) begin
            rd(2'd0, c); rd(2'd3, dd);
            if (!c[31] && !dd[31]) return;
        end
        check("R7 busy timeout", 1, 0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); check("R1 cfg", v, 0);
        rd(2'd1, v); check("R1 ctrl", v, 0);
        rd(2'd3, v); check("R1 data", v, 0);
        check("R1 mdc/oe", {mdc, mdio_oe}, 0);
    endtask

    task automatic t_c22_write();
        logic [31:0] v;
        wr(2'd0, 32'h0000_0102);
        wr(2'd1, {22'd0, 5'h0A, 5'h03});
        wr(2'd2, 32'h1234);
        repeat (20) @(negedge clk);
        rd(2'd0, v); check("R5 no launch on addr (cfg busy)", v[31], 0);
        check("R5 no launch on addr (line)", mdio_oe, 0);
        wr(2'd3, 32'hBEEF);
        rd(2'd3, v); check("R7 data busy on write", v[31], 1);
        wait_idle();
        check("R4 R5 c22 write frame", mon_bits, exp_frame(0, 2'b01, {5'h0A, 5'h03}, 16'hBEEF));
        check("R4 bit count", mon_cnt, 64);
    endtask

    task automatic t_c22_read();
        logic [31:0] v;
        logic [63:0] e;
        phy_en = 1; phy_read = 1; phy_val = 16'h5A3C;
        wr(2'd1, 32'h8000 | {22'd0, 5'h0A, 5'h07});
        rd(2'd3, v); check("R7 data busy on read", v[31], 1);
        wait_idle();
        rd(2'd3, v); check("R7 read result", v[15:0], 16'h5A3C);
        rd(2'd0, v); check("R8 no error", v[30], 0);
        e = exp_frame(0, 2'b10, {5'h0A, 5'h07}, 16'h0000);
        check("R4 c22 read header", mon_bits[63:18], e[63:18]);
        check("R8 turnaround seen", mon_bits[17:16], 2'b10);
        check("R8 released during TA+data", {mon_oe[63:46], mon_oe[17:0]}, {18'h3FFFF, 18'h0});
    endtask

    task automatic t_read_err();
        logic [31:0] v;
        phy_en = 0;
        wr(2'd1, 32'h8000 | {22'd0, 5'h01, 5'h02});
        wait_idle();
        rd(2'd0, v); check("R8 error latched", v[30], 1);
        phy_en = 1; phy_val = 16'h0001;
        wr(2'd1, 32'h8000 | {22'd0, 5'h01, 5'h02});
        rd(2'd0, v); check("R9 error cleared at start", v[30], 0);
        wait_idle();
        rd(2'd0, v); check("R9 error stays clear", v[30], 0);
    endtask

    task automatic t_c45();
        logic [31:0] v;
        logic [63:0] e;
        phy_read = 0;
        wr(2'd0, 32'h0000_1001);
        wr(2'd1, {22'd0, 5'h03, 5'h01});
        wr(2'd2, 32'hC0DE);
        rd(2'd0, v); check("R6 cfg busy", v[31], 1);
        rd(2'd3, v); check("R6 data not busy", v[31], 0);
        wait_idle();
        check("R4 R6 c45 addr frame", mon_bits, exp_frame(1, 2'b00, {5'h03, 5'h01}, 16'hC0DE));
        wr(2'd3, 32'h0F0F);
        rd(2'd3, v); check("R7 c45 write busy", v[31], 1);
        wait_idle();
        check("R4 c45 write frame", mon_bits, exp_frame(1, 2'b01, {5'h03, 5'h01}, 16'h0F0F));
        phy_read = 1; phy_val = 16'hA5C3;
        wr(2'd1, 32'h8000 | {22'd0, 5'h03, 5'h01});
        wait_idle();
        e = exp_frame(1, 2'b11, {5'h03, 5'h01}, 16'h0);
        check("R4 c45 read header", mon_bits[63:18], e[63:18]);
        rd(2'd3, v); check("R7 c45 read result", v[15:0], 16'hA5C3);
        phy_read = 0;
    endtask

    task automatic t_ignore();
        logic [31:0] v;
        wr(2'd0, 32'h0000_0102);
        wr(2'd1, {22'd0, 5'h04, 5'h05});
        wr(2'd3, 32'h1111);
        wr(2'd3, 32'h2222);
        wr(2'd1, 32'h8000 | {22'd0, 5'h1F, 5'h1F});
        wait_idle();
        rd(2'd3, v); check("R10 data unchanged", v[15:0], 16'h1111);
        rd(2'd1, v); check("R10 ctrl unchanged", v[9:0], {5'h04, 5'h05});
        check("R10 frame carried first data", mon_bits, exp_frame(0, 2'b01, {5'h04, 5'h05}, 16'h1111));
        repeat (200) @(negedge clk);
        check("R10 no extra frame", mon_cnt, 64);
        check("R2 mdc idle low", mdc, 0);
    endtask

    task automatic t_timing(input int dv, input int hd);
        int cyc, last_fall, first_rise, period, delay;
        logic prev_o, prev_m;
        wr(2'd0, (hd << 8) | dv);
        wr(2'd3, 32'h00FF);
        cyc = 0; last_fall = 0; first_rise = -1; period = -1; delay = -1;
        prev_o = mdio_o; prev_m = mdc;
        for (int i = 0; i < 2000 && (period < 0 || delay < 0); i++) begin
            @(negedge clk); cyc++;
            if (mdc && !prev_m) begin
                if (first_rise < 0) first_rise = cyc;
                else if (period < 0) period = cyc - first_rise;
            end
            if (!mdc && prev_m) last_fall = cyc;
            if (prev_o && !mdio_o && delay < 0) delay = cyc - last_fall;
            prev_o = mdio_o; prev_m = mdc;
        end
        check("R2 mdc period", period, 2 * (dv + 1));
        check("R3 hold delay", delay, hd);
        wait_idle();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_c22_write();
        t_c22_read();
        t_read_err();
        t_c45();
        t_ignore();
        t_timing(3, 2);
        t_timing(1, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule